// File: doc/BRIEF.md
# MESI Snooping Coherence Controller for a Line Array

This block keeps the four-state invalidate coherence state (Invalid, Shared, Exclusive, Modified) for a small array of cache lines that share one snooping bus. Two event streams reach it. Local requests (read, write, eviction) come from the cache pipeline. Snooped transactions (bus read, bus write, bus upgrade) come from other caches on the bus. For local requests it decides the bus command to issue and the next state. For snoops it produces the shared or dirty response, a flush strobe for writing dirty data back, and an error strobe for upgrades that the protocol should never produce.

Local requests pass through a two-state request machine. In `RQ_IDLE` the controller accepts one request and moves to `RQ_PEND`. In `RQ_PEND` it looks up the current state of the target line on every cycle. If the transition needs no bus transaction, it commits at once. Otherwise it raises a bus request and commits in the cycle the grant arrives, then returns to `RQ_IDLE`. When the line being changed is a bus read's target, the shared-line input is sampled in that grant cycle. The line states are `ST_I`, `ST_S`, `ST_E` and `ST_M`. The local transitions are: I-read to E or S, I-write to M, S-write to M by upgrade, E-write to M silently, eviction to I, with a writeback only from M. The snoop transitions are: bus read takes E or M to S, bus write takes S, E or M to I, and bus upgrade takes S to I.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid on `loc_state`, and `busy` and `bus_req` are low. The state encoding is I=00, S=01, E=10, M=11.
- R2: A local read (`loc_op`=00) of an Invalid line requests a bus read (`bus_cmd`=00). In the grant cycle the line becomes Exclusive if `shared_in` is low and Shared if it is high.
- R3: A local write (`loc_op`=01) requests a bus write (`bus_cmd`=01) from Invalid and a bus upgrade (`bus_cmd`=10) from Shared. In both cases the line ends in Modified.
- R4: A local write to an Exclusive line moves it to Modified with no bus request. A local read of a Shared, Exclusive or Modified line raises no bus request and leaves the state unchanged.
- R5: A local eviction (`loc_op`=10) leaves every line Invalid. Only a Modified line first requests a writeback (`bus_cmd`=11).
- R6: A snooped bus read (`snp_op`=00) asserts `snp_shared` for Shared and Exclusive lines, and an Exclusive line becomes Shared. A Modified line asserts `snp_dirty` and `snp_flush` and becomes Shared. An Invalid line gives no response.
- R7: A snooped bus write (`snp_op`=01) takes Shared and Exclusive lines to Invalid with no response. A Modified line asserts `snp_dirty` and `snp_flush` and becomes Invalid.
- R8: A snooped bus upgrade (`snp_op`=10) takes a Shared line to Invalid. On an Exclusive or Modified line it pulses `snp_err` and leaves the state unchanged. `snp_op`=11 has no effect on any line.
- R9: `loc_valid` is accepted only while `busy` is low, and `busy` rises on the next cycle. A pending request pulses `loc_done` in its first pending cycle if it needs no bus, or otherwise in the cycle `bus_grant` is high, with `bus_req` held until then. `loc_valid` while busy is ignored.
- R10: When a snoop targets the pending line in the same cycle, the local commit waits for a later cycle. The bus command is then re-derived from the line's updated state, so a pending upgrade on a line invalidated by a snoop becomes a bus write.
- R11: Snoop responses appear in the same cycle as `snp_valid`. The snooped line's new state is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_valid | input | 1 | Local request strobe |
| loc_op | input | 2 | Local operation: 00 read, 01 write, 10 evict, 11 no-op |
| loc_line | input | IDX_W | Line addressed by a new local request; also selects `loc_state` |
| bus_grant | input | 1 | Bus granted to this controller's pending request |
| shared_in | input | 1 | Shared-line wire, sampled in a bus read's grant cycle |
| snp_valid | input | 1 | Snooped transaction strobe |
| snp_op | input | 2 | Snooped operation: 00 bus read, 01 bus write, 10 upgrade, 11 none |
| snp_line | input | IDX_W | Line targeted by the snoop |
| busy | output | 1 | A local request is pending |
| bus_req | output | 1 | Request for the bus |
| bus_cmd | output | 2 | Bus command: 00 read, 01 write, 10 upgrade, 11 writeback |
| bus_line | output | IDX_W | Line of the pending request |
| loc_done | output | 1 | Pending local request commits this cycle |
| loc_state | output | 2 | Current state of line `loc_line` |
| snp_shared | output | 1 | Snoop response: clean copy held |
| snp_dirty | output | 1 | Snoop response: modified copy held |
| snp_flush | output | 1 | Dirty data written back for this snoop |
| snp_err | output | 1 | Upgrade snooped on an Exclusive or Modified line |

## Verification
On every cycle the assertions check the following: the shared and dirty responses are never asserted together, a flush always comes with a dirty response, and an error pulse occurs only for an upgrade snoop and never with a response. They also check the handshake: a bus request appears only while busy, busy rises only after an accepted request, and a pending request either stays pending or commits and frees the controller. The full transition table needs the bench's scenarios. These cover which next state each local operation and snoop produces from each state, which bus command is chosen, and the shared-line sampling. The scenarios also cover the deferral and re-derivation of a pending request when a snoop collides with it.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_t;

    typedef enum logic [1:0] {
        LOC_RD  = 2'b00,
        LOC_WR  = 2'b01,
        LOC_EV  = 2'b10,
        LOC_NOP = 2'b11
    } loc_op_t;

    typedef enum logic [1:0] {
        SNP_RD   = 2'b00,
        SNP_WR   = 2'b01,
        SNP_UPG  = 2'b10,
        SNP_NONE = 2'b11
    } snp_op_t;

    typedef enum logic [1:0] {
        CMD_RD  = 2'b00,
        CMD_WR  = 2'b01,
        CMD_UPG = 2'b10,
        CMD_WB  = 2'b11
    } bus_cmd_t;

endpackage

// File: rtl/mesi_local_decode.sv
module mesi_local_decode
    import mesi_pkg::*;
(
    input  mesi_t    cur,
    input  loc_op_t  op,
    input  logic     shared_in,
    output mesi_t    nxt,
    output logic     need_bus,
    output bus_cmd_t cmd
);

    always_comb begin
        nxt      = cur;
        need_bus = 1'b0;
        cmd      = CMD_RD;
        unique case (op)
            LOC_RD: begin
                // read hit in S, E or M needs nothing
                if (cur == ST_I) begin
                    need_bus = 1'b1;
                    cmd      = CMD_RD;
                    nxt      = shared_in ? ST_S : ST_E;
                end
            end
            LOC_WR: begin
                unique case (cur)
                    ST_I: begin
                        need_bus = 1'b1;
                        cmd      = CMD_WR;
                        nxt      = ST_M;
                    end
                    ST_S: begin
                        need_bus = 1'b1;
                        cmd      = CMD_UPG;
                        nxt      = ST_M;
                    end
                    ST_E: nxt = ST_M;
                    ST_M: nxt = ST_M;
                endcase
            end
            LOC_EV: begin
                nxt = ST_I;
                if (cur == ST_M) begin
                    need_bus = 1'b1;
                    cmd      = CMD_WB;
                end
            end
            LOC_NOP: nxt = cur;
        endcase
    end

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
(
    input  logic    valid,
    input  mesi_t   cur,
    input  snp_op_t op,
    output logic    upd,
    output mesi_t   nxt,
    output logic    shared_o,
    output logic    dirty_o,
    output logic    flush_o,
    output logic    err_o
);

    always_comb begin
        upd      = 1'b0;
        nxt      = cur;
        shared_o = 1'b0;
        dirty_o  = 1'b0;
        flush_o  = 1'b0;
        err_o    = 1'b0;
        if (valid) begin
            unique case (op)
                SNP_RD: begin
                    unique case (cur)
                        ST_I: ;
                        ST_S: shared_o = 1'b1;
                        ST_E: begin
                            shared_o = 1'b1;
                            upd      = 1'b1;
                            nxt      = ST_S;
                        end
                        ST_M: begin
                            dirty_o = 1'b1;
                            flush_o = 1'b1;
                            upd     = 1'b1;
                            nxt     = ST_S;
                        end
                    endcase
                end
                SNP_WR: begin
                    unique case (cur)
                        ST_I: ;
                        ST_S, ST_E: begin
                            upd = 1'b1;
                            nxt = ST_I;
                        end
                        ST_M: begin
                            dirty_o = 1'b1;
                            flush_o = 1'b1;
                            upd     = 1'b1;
                            nxt     = ST_I;
                        end
                    endcase
                end
                SNP_UPG: begin
                    unique case (cur)
                        ST_I: ;
                        ST_S: begin
                            upd = 1'b1;
                            nxt = ST_I;
                        end
                        ST_E, ST_M: err_o = 1'b1;
                    endcase
                end
                SNP_NONE: ;
            endcase
        end
    end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_valid,
    input  loc_op_t          loc_op,
    input  logic [IDX_W-1:0] loc_line,
    input  logic             need_bus,
    input  logic             bus_grant,
    input  logic             collide,
    output logic             busy,
    output logic             bus_req,
    output logic             commit,
    output loc_op_t          pend_op,
    output logic [IDX_W-1:0] pend_line
);

    typedef enum logic {
        RQ_IDLE = 1'b0,
        RQ_PEND = 1'b1
    } rq_t;

    rq_t rq_state;
    rq_t rq_next;

    always_comb begin
        rq_next = rq_state;
        unique case (rq_state)
            RQ_IDLE: if (loc_valid) rq_next = RQ_PEND;
            RQ_PEND: if (commit)    rq_next = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_state  <= RQ_IDLE;
            pend_op   <= LOC_NOP;
            pend_line <= '0;
        end else begin
            rq_state <= rq_next;
            if (rq_state == RQ_IDLE && loc_valid) begin
                pend_op   <= loc_op;
                pend_line <= loc_line;
            end
        end
    end

    always_comb begin
        busy    = 1'b0;
        bus_req = 1'b0;
        commit  = 1'b0;
        unique case (rq_state)
            RQ_IDLE: ;
            RQ_PEND: begin
                busy    = 1'b1;
                bus_req = need_bus;
                commit  = !collide && (!need_bus || bus_grant);
            end
        endcase
    end

endmodule

// File: rtl/mesi_state_array.sv
module mesi_state_array
    import mesi_pkg::*;
#(
    parameter int LINES = 8,
    parameter int IDX_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  snp_we,
    input  logic [IDX_W-1:0]      snp_idx,
    input  mesi_t                 snp_nxt,
    input  logic                  loc_we,
    input  logic [IDX_W-1:0]      loc_idx,
    input  mesi_t                 loc_nxt,
    output logic [LINES-1:0][1:0] states
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic snp_hit;
        logic loc_hit;
        assign snp_hit = snp_we && (snp_idx == IDX_W'(g));
        assign loc_hit = loc_we && (loc_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                states[g] <= ST_I;
            end else if (snp_hit) begin
                states[g] <= snp_nxt;
            end else if (loc_hit) begin
                states[g] <= loc_nxt;
            end
        end
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_valid,
    input  logic [1:0]       loc_op,
    input  logic [IDX_W-1:0] loc_line,
    input  logic             bus_grant,
    input  logic             shared_in,
    input  logic             snp_valid,
    input  logic [1:0]       snp_op,
    input  logic [IDX_W-1:0] snp_line,
    output logic             busy,
    output logic             bus_req,
    output logic [1:0]       bus_cmd,
    output logic [IDX_W-1:0] bus_line,
    output logic             loc_done,
    output logic [1:0]       loc_state,
    output logic             snp_shared,
    output logic             snp_dirty,
    output logic             snp_flush,
    output logic             snp_err
);

    logic [LINES-1:0][1:0] line_st;
    loc_op_t               pend_op;
    logic [IDX_W-1:0]      pend_line;
    mesi_t                 loc_cur;
    mesi_t                 loc_nxt;
    mesi_t                 snp_cur;
    mesi_t                 snp_nxt;
    logic                  need_bus;
    bus_cmd_t              cmd;
    logic                  snp_upd;
    logic                  commit;
    logic                  collide;

    assign loc_cur = mesi_t'(line_st[pend_line]);
    assign snp_cur = mesi_t'(line_st[snp_line]);
    assign collide = snp_valid && (snp_line == pend_line);

    mesi_local_decode u_local (
        .cur       (loc_cur),
        .op        (pend_op),
        .shared_in (shared_in),
        .nxt       (loc_nxt),
        .need_bus  (need_bus),
        .cmd       (cmd)
    );

    mesi_snoop_resp u_snoop (
        .valid    (snp_valid),
        .cur      (snp_cur),
        .op       (snp_op_t'(snp_op)),
        .upd      (snp_upd),
        .nxt      (snp_nxt),
        .shared_o (snp_shared),
        .dirty_o  (snp_dirty),
        .flush_o  (snp_flush),
        .err_o    (snp_err)
    );

    mesi_req_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .loc_valid (loc_valid),
        .loc_op    (loc_op_t'(loc_op)),
        .loc_line  (loc_line),
        .need_bus  (need_bus),
        .bus_grant (bus_grant),
        .collide   (collide),
        .busy      (busy),
        .bus_req   (bus_req),
        .commit    (commit),
        .pend_op   (pend_op),
        .pend_line (pend_line)
    );

    mesi_state_array #(.LINES(LINES), .IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .snp_we  (snp_upd),
        .snp_idx (snp_line),
        .snp_nxt (snp_nxt),
        .loc_we  (commit),
        .loc_idx (pend_line),
        .loc_nxt (loc_nxt),
        .states  (line_st)
    );

    assign bus_cmd   = cmd;
    assign bus_line  = pend_line;
    assign loc_done  = commit;
    assign loc_state = line_st[loc_line];

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       loc_valid,
    input logic       busy,
    input logic       bus_req,
    input logic       loc_done,
    input logic       snp_valid,
    input logic [1:0] snp_op,
    input logic       snp_shared,
    input logic       snp_dirty,
    input logic       snp_flush,
    input logic       snp_err
);

    AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_shared && snp_dirty)); // R6

    AST_FLUSH_WITH_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> snp_dirty); // R7

    AST_ERR_ON_UPGRADE: assert property (@(posedge clk) disable iff (!rst_n)
        snp_err |-> (snp_valid && snp_op == 2'b10 && !snp_shared && !snp_dirty)); // R8

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy); // R9

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(loc_valid)); // R9

    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        loc_done |=> !busy); // R9

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !loc_done) |=> busy); // R10

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .loc_valid  (loc_valid),
    .busy       (busy),
    .bus_req    (bus_req),
    .loc_done   (loc_done),
    .snp_valid  (snp_valid),
    .snp_op     (snp_op),
    .snp_shared (snp_shared),
    .snp_dirty  (snp_dirty),
    .snp_flush  (snp_flush),
    .snp_err    (snp_err)
);

// File: tb/tb_mesi_line_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_line_ctrl;

    localparam int LINES = 8;
    localparam int IW    = 3;
    localparam int NV    = 23;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          loc_valid = 1'b0;
    logic [1:0]    loc_op = 2'b11;
    logic [IW-1:0] loc_line = '0;
    logic          bus_grant = 1'b0;
    logic          shared_in = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_op = 2'b11;
    logic [IW-1:0] snp_line = '0;
    logic          busy, bus_req, loc_done;
    logic [1:0]    bus_cmd, loc_state;
    logic [IW-1:0] bus_line;
    logic          snp_shared, snp_dirty, snp_flush, snp_err;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    mesi_line_ctrl #(.LINES(LINES)) dut (
        .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_op(loc_op),
        .loc_line(loc_line), .bus_grant(bus_grant), .shared_in(shared_in),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_line(snp_line),
        .busy(busy), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_line(bus_line),
        .loc_done(loc_done), .loc_state(loc_state), .snp_shared(snp_shared),
        .snp_dirty(snp_dirty), .snp_flush(snp_flush), .snp_err(snp_err)
    );

    // {kind(1: snoop), op(2), line(3), shared_in(1), exp_req(1), exp_cmd(2), exp_resp{sh,dt,fl,er}(4), exp_state(2)}
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 2'd0, 4'b0000, 2'd2}, // R2 I read, alone -> E
        {1'b0, 2'd1, 3'd0, 1'b0, 1'b0, 2'd0, 4'b0000, 2'd3}, // R4 E write silent -> M
        {1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 2'd0, 4'b0000, 2'd3}, // R4 M read hit
        {1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 2'd0, 4'b0110, 2'd1}, // R6 bus read on M -> S dirty
        {1'b0, 2'd1, 3'd0, 1'b0, 1'b1, 2'd2, 4'b0000, 2'd3}, // R3 S write upgrade -> M
        {1'b1, 2'd1, 3'd0, 1'b0, 1'b0, 2'd0, 4'b0110, 2'd0}, // R7 bus write on M -> I dirty
        {1'b0, 2'd0, 3'd1, 1'b1, 1'b1, 2'd0, 4'b0000, 2'd1}, // R2 I read, shared -> S
        {1'b1, 2'd2, 3'd1, 1'b0, 1'b0, 2'd0, 4'b0000, 2'd0}, // R8 upgrade on S -> I
        {1'b0, 2'd1, 3'd2, 1'b0, 1'b1, 2'd1, 4'b0000, 2'd3}, // R3 I write -> M
        {1'b0, 2'd2, 3'd2, 1'b0, 1'b1, 2'd3, 4'b0000, 2'd0}, // R5 M evict writeback
        {1'b0, 2'd0, 3'd3, 1'b0, 1'b1, 2'd0, 4'b0000, 2'd2}, // R2 -> E
        {1'b1, 2'd2, 3'd3, 1'b0, 1'b0, 2'd0, 4'b0001, 2'd2}, // R8 upgrade on E error
        {1'b1, 2'd0, 3'd3, 1'b0, 1'b0, 2'd0, 4'b1000, 2'd1}, // R6 bus read on E -> S
        {1'b1, 2'd0, 3'd3, 1'b0, 1'b0, 2'd0, 4'b1000, 2'd1}, // R6 bus read on S stays
        {1'b0, 2'd0, 3'd3, 1'b0, 1'b0, 2'd0, 4'b0000, 2'd1}, // R4 S read hit
        {1'b0, 2'd2, 3'd3, 1'b0, 1'b0, 2'd0, 4'b0000, 2'd0}, // R5 S evict silent
        {1'b1, 2'd0, 3'd3, 1'b0, 1'b0, 2'd0, 4'b0000, 2'd0}, // R6 bus read on I no action
        {1'b0, 2'd1, 3'd4, 1'b0, 1'b1, 2'd1, 4'b0000, 2'd3}, // R3 I write -> M
        {1'b1, 2'd2, 3'd4, 1'b0, 1'b0, 2'd0, 4'b0001, 2'd3}, // R8 upgrade on M error
        {1'b0, 2'd0, 3'd5, 1'b0, 1'b1, 2'd0, 4'b0000, 2'd2}, // R2 -> E
        {1'b1, 2'd1, 3'd5, 1'b0, 1'b0, 2'd0, 4'b0000, 2'd0}, // R7 bus write on E -> I
        {1'b0, 2'd2, 3'd5, 1'b0, 1'b0, 2'd0, 4'b0000, 2'd0}, // R5 I evict
        {1'b0, 2'd0, 3'd6, 1'b0, 1'b1, 2'd0, 4'b0000, 2'd2}  // R2 -> E, then R5 below
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_local(input logic [IW-1:0] ln, input logic [1:0] op, input logic shin,
                             input logic ereq, input logic [1:0] ecmd, input logic [1:0] est,
                             input string tag);
        @(negedge clk);
        loc_valid = 1'b1; loc_op = op; loc_line = ln;
        @(negedge clk);
        loc_valid = 1'b0;
        #1;
        check({tag, " busy"}, int'(busy), 1);
        check({tag, " bus_req"}, int'(bus_req), int'(ereq));
        if (ereq) begin
            check({tag, " bus_cmd"}, int'(bus_cmd), int'(ecmd));
            check({tag, " bus_line"}, int'(bus_line), int'(ln));
            for (int w = 0; w < 2; w++) begin
                check({tag, " no done before grant"}, int'(loc_done), 0);
                @(negedge clk);
                #1;
                check({tag, " bus_req held"}, int'(bus_req), 1);
            end
            bus_grant = 1'b1; shared_in = shin;
            #1;
            check({tag, " done on grant"}, int'(loc_done), 1);
            @(negedge clk);
            bus_grant = 1'b0; shared_in = 1'b0;
            #1;
        end else begin
            check({tag, " done at once"}, int'(loc_done), 1);
            @(negedge clk);
            #1;
        end
        check({tag, " idle"}, int'(busy), 0);
        check({tag, " state"}, int'(loc_state), int'(est));
    endtask

    task automatic run_snoop(input logic [IW-1:0] ln, input logic [1:0] op,
                             input logic [3:0] eresp, input logic [1:0] est, input string tag);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_line = ln;
        #1;
        check({tag, " response"}, int'({snp_shared, snp_dirty, snp_flush, snp_err}), int'(eresp));
        @(negedge clk);
        snp_valid = 1'b0; snp_op = 2'b11; loc_line = ln;
        #1;
        check({tag, " state"}, int'(loc_state), int'(est));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        check("R1 busy", int'(busy), 0);
        check("R1 bus_req", int'(bus_req), 0);
        for (int i = 0; i < LINES; i++) begin
            loc_line = IW'(i);
            #1;
            check("R1 line invalid", int'(loc_state), 0);
        end

        for (int v = 0; v < NV; v++) begin
            logic [15:0] e;
            e = VEC[v];
            if (e[15])
                run_snoop(e[12:10], e[14:13], e[5:2], e[1:0], $sformatf("vector %0d", v));
            else
                run_local(e[12:10], e[14:13], e[9], e[8], e[7:6], e[1:0], $sformatf("vector %0d", v));
        end
        // R5 evict of Exclusive is silent
        run_local(3'd6, 2'd2, 1'b0, 1'b0, 2'd0, 2'd0, "R5 E evict");

        // R9 request while busy is ignored
        @(negedge clk);
        loc_valid = 1'b1; loc_op = 2'd0; loc_line = 3'd7;
        @(negedge clk);
        loc_op = 2'd1; loc_line = 3'd6;
        #1;
        check("R9 first request pending", int'(bus_req), 1);
        check("R9 command is read", int'(bus_cmd), 0);
        @(negedge clk);
        loc_valid = 1'b0; bus_grant = 1'b1;
        #1;
        check("R9 done on grant", int'(loc_done), 1);
        @(negedge clk);
        bus_grant = 1'b0;
        #1;
        check("R9 idle after commit", int'(busy), 0);
        check("R9 ignored line untouched", int'(loc_state), 0);
        loc_line = 3'd7;
        #1;
        check("R9 accepted line exclusive", int'(loc_state), 2);

        // R10 collision defers commit and re-derives the command
        run_local(3'd0, 2'd0, 1'b1, 1'b1, 2'd0, 2'd1, "R10 setup shared");
        @(negedge clk);
        loc_valid = 1'b1; loc_op = 2'd1; loc_line = 3'd0;
        @(negedge clk);
        loc_valid = 1'b0;
        #1;
        check("R10 upgrade requested", int'(bus_cmd), 2);
        snp_valid = 1'b1; snp_op = 2'd1; snp_line = 3'd0; bus_grant = 1'b1;
        #1;
        check("R10 commit deferred", int'(loc_done), 0);
        @(negedge clk);
        snp_valid = 1'b0; snp_op = 2'b11;
        #1;
        check("R10 command now bus write", int'(bus_cmd), 1);
        check("R10 done after deferral", int'(loc_done), 1);
        @(negedge clk);
        bus_grant = 1'b0;
        #1;
        check("R10 idle", int'(busy), 0);
        check("R10 line modified", int'(loc_state), 3);

        // R8 R11 snoop op 11 has no effect on a Modified line
        run_snoop(3'd0, 2'd3, 4'b0000, 2'd3, "R8 R11 null snoop");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule